// File: doc/BRIEF.md
# Buffered PWM Time Base Counter

This block is the period timer behind a motor-control PWM generator. A 15-bit counter is fed through a selectable input prescaler. It runs in one of four counting modes: free-running sawtooth, one-shot sawtooth, continuous triangle, and triangle with an interrupt at both turning points. Duty-cycle comparators elsewhere on the chip read the counter value, the slope flag and the zero and period flags to form their outputs.

The period value is written into a shadow register. The shadow reaches the active compare register only at instants that cannot tear a PWM cycle: at the wrap to zero for the sawtooth modes, at the bottom of the triangle for the up/down modes, and on every cycle while the timer is disabled. Period-match events pass through a 4-bit postscaler before they raise the single-cycle interrupt pulse. The exception is the double-interrupt triangle mode, which interrupts at both ends of the triangle and ignores the postscaler.

Control, counter and period values each have their own write strobe. A control write or a counter write restarts both the prescaler and the postscaler. A control write leaves the count as it is. A counter write loads a new count whether or not the timer runs.

Top module: `pwm_tbase`

## Requirements
- R1: After a synchronous reset the count is 0, `count_down` is 0, `irq` is 0 and `at_zero` is 1.
- R2: `ctl_ckps` selects the prescale ratio: 2'b00 = 1, 2'b01 = 4, 2'b10 = 16, 2'b11 = 64. While enabled, the counter takes one step every ratio clock cycles. The first step comes ratio cycles after the enabling control write.
- R3: In free-running mode (`ctl_mode` = 2'b00) the counter steps 0,1,..,P and then returns to 0, where P is the active period. The step out of P is a period-match event.
- R4: In single-shot mode (`ctl_mode` = 2'b01) the counter runs as in R3 for one period. At the period match it clears the enable bit, so it then rests at 0.
- R5: In the up/down modes (`ctl_mode` = 2'b10 and 2'b11) the counter rises to P and then falls to 0, and repeats. `count_down` is 1 while the counter is descending and 0 whenever the count is 0. The step that leaves P is the period-match event.
- R6: In modes 2'b00, 2'b01 and 2'b10, postscaler code n (`ctl_post`, 0..15) raises `irq` once for every n+1 period-match events.
- R7: In mode 2'b11, `irq` is raised for every step taken from count 0 and for every period-match event, whatever the postscaler code is.
- R8: A period write goes to a shadow register. The shadow is copied to the active period at the period-match step in modes 2'b00 and 2'b01, and at the step taken from 0 in the up/down modes. While the timer is disabled the shadow is copied on every cycle.
- R9: A control write or a counter write clears the prescaler and the postscaler and takes no counter step in that cycle. A control write leaves the count unchanged. A counter write loads `cnt_wdata` whether or not the timer is enabled.
- R10: While the timer is disabled and no counter write occurs, the count holds its value.
- R11: `irq` is registered. It is high for exactly the one cycle after each clock edge at which an interrupting event occurred. `at_zero` shows count == 0 and `at_period` shows count == active period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit written by a control write |
| ctl_mode | input | 2 | Counting mode written by a control write |
| ctl_ckps | input | 2 | Prescale code written by a control write |
| ctl_post | input | 4 | Postscale code written by a control write |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 15 | Value loaded into the counter |
| per_wr | input | 1 | Period (shadow) write strobe |
| per_wdata | input | 15 | Value written into the shadow period |
| count | output | 15 | Current counter value |
| count_down | output | 1 | Counter is on the descending slope |
| at_zero | output | 1 | Count equals zero |
| at_period | output | 1 | Count equals the active period |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
A write strobe takes effect at the clock edge on which it is sampled. The new count, the cleared prescaler and the shadow value can be seen right after that edge. With prescale code k the first counter step lands ratio edges after the enabling control write. While disabled, the active period follows the shadow one edge after the shadow changes. The interrupt is registered, so `irq` is high during the cycle after the edge at which the counter took the event step. The bench drives inputs just after a falling edge and samples every output at the following falling edge. It counts edges from the enabling write, so each expected count, slope and pulse total is fixed to a known edge number.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    localparam int TB_CNT_W  = 15;
    localparam int TB_POST_W = 4;
    localparam int TB_PRE_W  = 6;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'b00,
        MODE_ONCE   = 2'b01,
        MODE_UPDN   = 2'b10,
        MODE_UPDN2X = 2'b11
    } tb_mode_e;

    typedef struct packed {
        logic                 en;
        tb_mode_e             mode;
        logic [1:0]           ckps;
        logic [TB_POST_W-1:0] post;
    } tb_ctl_t;

    // Terminal value of the prescale counter for each ratio code (ratio - 1).
    function automatic logic [TB_PRE_W-1:0] pre_last(input logic [1:0] code);
        logic [TB_PRE_W-1:0] one;
        one = '0;
        one[0] = 1'b1;
        return (one << (2 * code)) - one;
    endfunction

    function automatic logic is_updown(input tb_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/pwm_tbase_presc.sv
module pwm_tbase_presc
    import pwm_tbase_pkg::*;
#(
    parameter int PRE_W = TB_PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [1:0] ckps,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    assign last = PRE_W'(pre_last(ckps));
    assign tick = en && !clr && (pre_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr || !en) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> (pre_q <= $past(last) || $past(last) != last)) // R2
        else $error("prescale counter beyond ratio");

endmodule

// File: rtl/pwm_tbase_postsc.sv
module pwm_tbase_postsc
    import pwm_tbase_pkg::*;
#(
    parameter int POST_W = TB_POST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              evt,
    input  logic [POST_W-1:0] sel,
    output logic              fire
);
    logic [POST_W-1:0] ev_q;

    assign fire = evt && (ev_q == sel);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ev_q <= '0;
        end else if (evt) begin
            ev_q <= fire ? '0 : ev_q + POST_W'(1);
        end
    end

    AST_POST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ev_q == '0)) // R9
        else $error("postscaler not cleared by write");

endmodule

// File: rtl/pwm_tbase_core.sv
module pwm_tbase_core
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = TB_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  tb_mode_e         mode,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic [CNT_W-1:0] per_act,
    output logic             match_evt,
    output logic             zero_evt
);
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             down_nxt;
    logic             match_raw;
    logic             load_per;
    logic             at_top;

    assign at_top = (cnt >= per_act);

    always_comb begin
        cnt_nxt   = cnt + CNT_W'(1);
        down_nxt  = 1'b0;
        match_raw = 1'b0;
        if (!is_updown(mode)) begin
            if (at_top) begin
                cnt_nxt   = '0;
                match_raw = 1'b1;
            end
        end else if (down && cnt != '0) begin
            cnt_nxt  = cnt - CNT_W'(1);
            down_nxt = (cnt_nxt != '0);
        end else if (at_top && cnt != '0) begin
            cnt_nxt   = cnt - CNT_W'(1);
            down_nxt  = (cnt_nxt != '0);
            match_raw = 1'b1;
        end else if (at_top) begin
            cnt_nxt = '0;
        end
    end

    assign match_evt = tick && match_raw;
    assign zero_evt  = tick && (cnt == '0);
    assign load_per  = is_updown(mode) ? zero_evt : match_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            down     <= 1'b0;
            shadow_q <= '0;
            per_act  <= '0;
        end else begin
            if (per_wr) begin
                shadow_q <= per_wdata;
            end
            if (!en || load_per) begin
                per_act <= shadow_q;
            end
            if (cnt_wr) begin
                cnt  <= cnt_wdata;
                down <= 1'b0;
            end else if (tick) begin
                cnt  <= cnt_nxt;
                down <= down_nxt;
            end else if (!is_updown(mode)) begin
                down <= 1'b0;
            end
        end
    end

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(cnt_wdata))) // R9
        else $error("counter write not taken");

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_wr) |=> (cnt == $past(cnt))) // R10
        else $error("counter moved while disabled");

    AST_SHADOW_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (per_act == $past(shadow_q))) // R8
        else $error("active period not following shadow while disabled");

    AST_DIR_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !down) // R5
        else $error("descending flag set at zero");

endmodule

// File: rtl/pwm_tbase.sv
module pwm_tbase
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W  = TB_CNT_W,
    parameter int POST_W = TB_POST_W,
    parameter int PRE_W  = TB_PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic [1:0]        ctl_mode,
    input  logic [1:0]        ctl_ckps,
    input  logic [POST_W-1:0] ctl_post,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              per_wr,
    input  logic [CNT_W-1:0]  per_wdata,
    output logic [CNT_W-1:0]  count,
    output logic              count_down,
    output logic              at_zero,
    output logic              at_period,
    output logic              irq
);
    tb_ctl_t          ctl_q;
    logic             restart;
    logic             tick;
    logic             match_evt;
    logic             zero_evt;
    logic             post_fire;
    logic             irq_d;
    logic [CNT_W-1:0] per_act;

    assign restart = ctl_wr || cnt_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{en: 1'b0, mode: MODE_FREE, ckps: 2'b00, post: '0};
        end else if (ctl_wr) begin
            ctl_q <= '{en: ctl_en, mode: tb_mode_e'(ctl_mode), ckps: ctl_ckps, post: ctl_post};
        end else if (match_evt && ctl_q.mode == MODE_ONCE) begin
            ctl_q.en <= 1'b0;
        end
    end

    pwm_tbase_presc #(.PRE_W(PRE_W)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .en   (ctl_q.en),
        .ckps (ctl_q.ckps),
        .tick (tick)
    );

    pwm_tbase_core #(.CNT_W(CNT_W)) core_i (
        .clk       (clk),
        .rst       (rst),
        .en        (ctl_q.en),
        .mode      (ctl_q.mode),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .per_wr    (per_wr),
        .per_wdata (per_wdata),
        .cnt       (count),
        .down      (count_down),
        .per_act   (per_act),
        .match_evt (match_evt),
        .zero_evt  (zero_evt)
    );

    pwm_tbase_postsc #(.POST_W(POST_W)) postsc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (restart),
        .evt  (match_evt),
        .sel  (ctl_q.post),
        .fire (post_fire)
    );

    assign irq_d = (ctl_q.mode == MODE_UPDN2X) ? (match_evt || zero_evt) : post_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= irq_d;
        end
    end

    assign at_zero   = (count == '0);
    assign at_period = (count == per_act);

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (match_evt && ctl_q.mode == MODE_ONCE && !ctl_wr) |=> !ctl_q.en) // R4
        else $error("single-shot did not stop");

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(match_evt || zero_evt)) // R11
        else $error("interrupt without a counter event");

    AST_CTL_KEEPS_CNT: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !cnt_wr) |=> (count == $past(count))) // R9
        else $error("control write disturbed the counter");

    AST_DBL_IGNORES_POST: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.mode == MODE_UPDN2X && match_evt) |=> irq) // R7
        else $error("double-update match without interrupt");

endmodule

// File: tb/pwm_tbase_tb.sv
module pwm_tbase_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 15;
    localparam int NVEC = 9;

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  ckps;
        logic [3:0]  post;
        logic [14:0] per;
        logic [15:0] ncyc;
        logic [14:0] exp_cnt;
        logic        exp_dir;
        logic [7:0]  exp_irq;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 2'b00, 4'd0, 15'd4,   16'd12, 15'd2, 1'b0, 8'd2},
        '{2'b00, 2'b00, 4'd1, 15'd4,   16'd22, 15'd2, 1'b0, 8'd2},
        '{2'b00, 2'b01, 4'd0, 15'd2,   16'd30, 15'd1, 1'b0, 8'd2},
        '{2'b00, 2'b10, 4'd0, 15'd0,   16'd50, 15'd0, 1'b0, 8'd3},
        '{2'b00, 2'b11, 4'd0, 15'd1,  16'd200, 15'd1, 1'b0, 8'd1},
        '{2'b10, 2'b00, 4'd0, 15'd3,   16'd14, 15'd2, 1'b0, 8'd2},
        '{2'b10, 2'b00, 4'd0, 15'd3,    16'd5, 15'd1, 1'b1, 8'd1},
        '{2'b11, 2'b00, 4'd5, 15'd3,   16'd14, 15'd2, 1'b0, 8'd5},
        '{2'b01, 2'b00, 4'd0, 15'd3,   16'd10, 15'd0, 1'b0, 8'd1}
    };
    localparam string TAGS [NVEC] = '{"R3", "R6", "R2", "R2", "R2", "R5", "R5", "R7", "R4"};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_wr = 1'b0, ctl_en = 1'b0, cnt_wr = 1'b0, per_wr = 1'b0;
    logic [1:0]    ctl_mode = 2'b00, ctl_ckps = 2'b00;
    logic [3:0]    ctl_post = 4'd0;
    logic [CW-1:0] cnt_wdata = '0, per_wdata = '0;
    logic [CW-1:0] count;
    logic          count_down, at_zero, at_period, irq;

    int checks = 0;
    int errors = 0;
    int pulses;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_tbase dut_i (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_mode(ctl_mode),
        .ctl_ckps(ctl_ckps), .ctl_post(ctl_post),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .count(count), .count_down(count_down),
        .at_zero(at_zero), .at_period(at_period), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock edge, then sample at the following falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq) pulses++;
        end
    endtask

    task automatic wr_ctl(input logic en, input logic [1:0] m, input logic [1:0] k,
                          input logic [3:0] p);
        ctl_en = en; ctl_mode = m; ctl_ckps = k; ctl_post = p; ctl_wr = 1'b1;
        step(1);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [CW-1:0] v);
        cnt_wdata = v; cnt_wr = 1'b1;
        step(1);
        cnt_wr = 1'b0;
    endtask

    task automatic wr_per(input logic [CW-1:0] v);
        per_wdata = v; per_wr = 1'b1;
        step(1);
        per_wr = 1'b0;
    endtask

    // Stop, load period and count 0, let the active period settle, then start.
    task automatic start(input logic [1:0] m, input logic [1:0] k, input logic [3:0] p,
                         input logic [CW-1:0] per);
        ctl_en = 1'b0; ctl_mode = m; ctl_ckps = k; ctl_post = p; ctl_wr = 1'b1;
        per_wdata = per; per_wr = 1'b1;
        cnt_wdata = '0; cnt_wr = 1'b1;
        step(1);
        ctl_wr = 1'b0; per_wr = 1'b0; cnt_wr = 1'b0;
        step(1);
        wr_ctl(1'b1, m, k, p);
        pulses = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pulses = 0;
        @(negedge clk);
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 count", int'(count), 0);
        check("R1 down", int'(count_down), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 at_zero", int'(at_zero), 1);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            start(VECS[v].mode, VECS[v].ckps, VECS[v].post, VECS[v].per);
            step(int'(VECS[v].ncyc));
            check({TAGS[v], " count"}, int'(count), int'(VECS[v].exp_cnt));
            check({TAGS[v], " down"}, int'(count_down), int'(VECS[v].exp_dir));
            check({TAGS[v], " irq pulses"}, pulses, int'(VECS[v].exp_irq));
        end
        check("R4 at_zero after one shot", int'(at_zero), 1);
        step(4);
        check("R4 rests at zero", int'(count), 0);

        // R8: shadow period only reaches active at the wrap
        start(2'b00, 2'b00, 4'd0, 15'd4);
        step(2);
        wr_per(15'd7);
        check("R8 count 3", int'(count), 3);
        step(1);
        check("R8 old period still active", int'(at_period), 1);
        step(1);
        check("R8 wrap at old period", int'(count), 0);
        step(5);
        check("R8 new period in use", int'(count), 5);
        check("R11 at_period off", int'(at_period), 0);

        // R9: control write keeps count and restarts prescaler
        start(2'b00, 2'b01, 4'd0, 15'd10);
        step(6);
        check("R9 count before ctl write", int'(count), 1);
        wr_ctl(1'b1, 2'b00, 2'b01, 4'd0);
        check("R9 count kept by ctl write", int'(count), 1);
        step(3);
        check("R9 prescaler restarted", int'(count), 1);
        step(1);
        check("R9 step after full ratio", int'(count), 2);

        // R9: counter write while running
        start(2'b00, 2'b00, 4'd0, 15'd10);
        step(2);
        wr_cnt(15'd5);
        check("R9 counter write", int'(count), 5);
        step(1);
        check("R9 runs on from written value", int'(count), 6);

        // R9/R6: counter write clears postscaler
        start(2'b00, 2'b00, 4'd1, 15'd1);
        step(2);
        wr_cnt(15'd0);
        pulses = 0;
        step(3);
        check("R9 postscaler cleared, no early irq", pulses, 0);
        step(1);
        check("R6 irq after two fresh matches", int'(irq), 1);
        step(1);
        check("R11 irq is one cycle", int'(irq), 0);

        // R10: hold while disabled, counter write still accepted
        start(2'b00, 2'b00, 4'd0, 15'd20);
        step(3);
        wr_ctl(1'b0, 2'b00, 2'b00, 4'd0);
        step(5);
        check("R10 holds while disabled", int'(count), 3);
        wr_cnt(15'd9);
        step(2);
        check("R9 write while disabled", int'(count), 9);

        // R8: period follows shadow while disabled
        wr_per(15'd9);
        step(1);
        check("R8 shadow copied while disabled", int'(at_period), 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule